// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit linear address into a physical address. It reads a page directory entry and, for ordinary pages, a page table entry through one memory port that carries a single access at a time. A directory entry with its large-page flag set ends the walk at the first level and maps a 4 MB region. Otherwise the table entry maps a 4 KB page. When the paging-enable control is low, the address is returned unchanged and memory is not touched.

Each walk checks the access against two privilege levels and two access kinds. A user-mode access needs the user flag in every entry it used. A user-mode write also needs the writable flag in every entry it used. Supervisor accesses skip both checks. A walk that succeeds writes back, one entry at a time, each entry whose accessed flag was clear. A write also marks the final page-table entry dirty. The result is a single-cycle response carrying the physical address and a two-bit fault code. The block has no translation cache: every request walks memory.

Top module: `pt_walker`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `req_ready` is 1 and `rsp_valid` and `mem_req` are 0.
- R2: With `ctl_paging_en` low, an accepted request is answered in the next cycle with `rsp_phys` equal to `req_lin` and `rsp_fault` 0. The walker issues no memory access, whatever the write and user inputs are.
- R3: An ordinary-page walk reads the directory entry at `{ctl_dir_base[31:12], lin[31:22], 2'b00}`, then the table entry at `{dir_entry[31:12], lin[21:12], 2'b00}`. It returns `{tbl_entry[31:12], lin[11:0]}`. Entry bits: 0 present, 1 writable, 2 user, 5 accessed, 6 dirty, 7 large page.
- R4: A present directory entry with bit 7 set maps a 4 MB page. The walker reads no table entry and returns `{dir_entry[31:22], lin[21:0]}`, so bits 21:12 of the entry are ignored. Bit 7 of a table entry is ignored.
- R5: If the directory entry has bit 0 clear, the result is fault code 1. If the table entry has bit 0 clear, the result is fault code 2. A faulting walk writes nothing to memory.
- R6: A user access (`req_user`=1) gets fault code 3 if any entry it used has bit 2 clear. A user write also gets fault code 3 if any entry it used has bit 1 clear. Supervisor accesses are never refused for these reasons. A refused walk writes nothing to memory.
- R7: A walk that succeeds writes back each entry it used whose bit 5 was clear, with bit 5 set and every other bit unchanged. It does not write back an entry that already had bit 5 set, unless R8 requires it.
- R8: A write that succeeds through a table entry whose bit 6 is clear writes that entry back with bit 6 set. Bit 6 is never set in a directory entry, including the leaf entry of a 4 MB page.
- R9: The directory write-back, if any, comes before the table write-back. Both complete before the response.
- R10: `mem_req` stays high, with `mem_addr`, `mem_we` and `mem_wdata` stable, until `mem_ack`. Only one access is outstanding at a time, and `mem_req` is low whenever `req_ready` is high.
- R11: `rsp_valid` is high for exactly one cycle per accepted request. `req_ready` is low from acceptance until that response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| ctl_paging_en | input | 1 | Translation enable |
| ctl_dir_base | input | 32 | Physical base of the page directory (bits 31:12 used) |
| req_valid | input | 1 | Request strobe, taken when `req_ready` is high |
| req_ready | output | 1 | Walker idle and able to take a request |
| req_lin | input | 32 | Linear address to translate |
| req_write | input | 1 | 1 for a write access |
| req_user | input | 1 | 1 for a user-mode access |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_phys | output | 32 | Physical address (meaningful when the fault code is 0) |
| rsp_fault | output | 2 | 0 none, 1 directory absent, 2 table absent, 3 privilege |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 for an entry write-back |
| mem_addr | output | 32 | Byte address of the entry |
| mem_wdata | output | 32 | Entry value to write |
| mem_ack | input | 1 | One-cycle completion of the current access |
| mem_rdata | input | 32 | Read data, valid with `mem_ack` |

## Verification
The assertions take for granted that `mem_ack` pulses for one cycle and only while `mem_req` is high. They also assume that `ctl_paging_en` and `ctl_dir_base` stay steady from acceptance to response, and that `mem_rdata` is valid in the acknowledge cycle. The bench memory model acknowledges only a pending request, after a programmable delay of zero to two cycles, and returns a word only together with the acknowledge. The bench changes the controls only while the walker is idle with no response pending. Requests are offered only when `req_ready` is high and are held for exactly one cycle.

// File: rtl/pt_walker_pkg.sv
// Package pt_walker_pkg
// Shared entry bit positions, fault codes and walk states for the page
// table walker. Assumes directory and table entries share one layout.
package pt_walker_pkg;

    // Entry flag positions (same layout at both levels)
    localparam int BIT_P   = 0;
    localparam int BIT_RW  = 1;
    localparam int BIT_US  = 2;
    localparam int BIT_PWT = 3;
    localparam int BIT_PCD = 4;
    localparam int BIT_A   = 5;
    localparam int BIT_D   = 6;
    localparam int BIT_PS  = 7;
    localparam int BIT_G   = 8;

    // Result codes reported on rsp_fault
    typedef enum logic [1:0] {
        FLT_NONE       = 2'd0,
        FLT_DIR_ABSENT = 2'd1,
        FLT_TBL_ABSENT = 2'd2,
        FLT_PRIV       = 2'd3
    } fault_e;

    // Walk sequencer states
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_DIR_RD,
        ST_DIR_EV,
        ST_TBL_RD,
        ST_TBL_EV,
        ST_DIR_WB,
        ST_TBL_WB,
        ST_DONE
    } walk_st_e;

endpackage

// File: rtl/pt_addr_gen.sv
// Module pt_addr_gen
// Forms the directory entry address, the table entry address and the
// final physical address from the linear address and the entry frames.
// Assumes one entry is ADDR_W/8 bytes and a page holds exactly 2**IDX_W
// entries (PAGE_SHIFT == IDX_W + log2 of the entry size).
module pt_addr_gen #(
    parameter int ADDR_W     = 32,
    parameter int PAGE_SHIFT = 12,
    parameter int IDX_W      = 10
) (
    input  logic [ADDR_W-1:0]            lin_i,
    input  logic [ADDR_W-1:PAGE_SHIFT]   base_frame_i,
    input  logic [ADDR_W-1:PAGE_SHIFT]   dir_frame_i,
    input  logic [ADDR_W-1:PAGE_SHIFT]   tbl_frame_i,
    input  logic                         large_i,
    output logic [ADDR_W-1:0]            dir_addr_o,
    output logic [ADDR_W-1:0]            tbl_addr_o,
    output logic [ADDR_W-1:0]            phys_o
);
    localparam int ENT_SHIFT   = $clog2(ADDR_W / 8);
    localparam int LARGE_SHIFT = PAGE_SHIFT + IDX_W;

    // Entry addresses: frame base plus index scaled by entry size
    always_comb begin
        dir_addr_o = {base_frame_i, lin_i[ADDR_W-1:LARGE_SHIFT], {ENT_SHIFT{1'b0}}};
        tbl_addr_o = {dir_frame_i, lin_i[LARGE_SHIFT-1:PAGE_SHIFT], {ENT_SHIFT{1'b0}}};
    end

    // Physical address: large pages keep only the top frame bits
    always_comb begin
        if (large_i) begin
            phys_o = {dir_frame_i[ADDR_W-1:LARGE_SHIFT], lin_i[LARGE_SHIFT-1:0]};
        end else begin
            phys_o = {tbl_frame_i, lin_i[PAGE_SHIFT-1:0]};
        end
    end

endmodule

// File: rtl/pt_perm_check.sv
// Module pt_perm_check
// Decides whether an access may use the entries walked so far. A user
// access needs the user flag at every used level; a user write also needs
// the writable flag. Supervisor accesses always pass. For a large page the
// table-level flags are not consulted.
module pt_perm_check (
    input  logic acc_user_i,
    input  logic acc_write_i,
    input  logic large_i,
    input  logic dir_us_i,
    input  logic dir_rw_i,
    input  logic tbl_us_i,
    input  logic tbl_rw_i,
    output logic grant_o
);
    logic lvl2_us;
    logic lvl2_rw;

    // Table-level flags count only when a table entry was used
    always_comb begin
        lvl2_us = large_i | tbl_us_i;
        lvl2_rw = large_i | tbl_rw_i;
    end

    // Combine the privilege and access-kind checks
    always_comb begin
        grant_o = !acc_user_i ||
                  ((dir_us_i && lvl2_us) && (!acc_write_i || (dir_rw_i && lvl2_rw)));
    end

endmodule

// File: rtl/pt_entry_upd.sv
// Module pt_entry_upd
// Computes the write-back image of one entry and whether a write-back is
// needed. Accessed is always set; dirty only when the caller asks for it,
// which the walker does only for the table level on a write.
module pt_entry_upd
    import pt_walker_pkg::*;
#(
    parameter int ENT_W = 32
) (
    input  logic [ENT_W-1:0] entry_i,
    input  logic             mark_dirty_i,
    output logic [ENT_W-1:0] entry_o,
    output logic             wb_need_o
);
    // Set the flags and flag a write-back when one of them was clear
    always_comb begin
        entry_o           = entry_i;
        entry_o[BIT_A]    = 1'b1;
        if (mark_dirty_i) begin
            entry_o[BIT_D] = 1'b1;
        end
        wb_need_o = !entry_i[BIT_A] || (mark_dirty_i && !entry_i[BIT_D]);
    end

endmodule

// File: rtl/pt_walker.sv
// Module pt_walker
// Two-level page table walker with one outstanding memory access. Reads
// the directory entry, stops there for a large page, otherwise reads the
// table entry; checks presence and protection; writes back accessed and
// dirty flags (directory first); then pulses a response. Assumes the
// control inputs stay steady during a walk and mem_ack pulses once per
// request with read data valid alongside.
module pt_walker
    import pt_walker_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int PAGE_SHIFT = 12,
    parameter int IDX_W      = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctl_paging_en,
    input  logic [ADDR_W-1:0] ctl_dir_base,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_lin,
    input  logic              req_write,
    input  logic              req_user,
    output logic              rsp_valid,
    output logic [ADDR_W-1:0] rsp_phys,
    output logic [1:0]        rsp_fault,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [ADDR_W-1:0] mem_wdata,
    input  logic              mem_ack,
    input  logic [ADDR_W-1:0] mem_rdata
);
    localparam int LEVELS = 2;
    localparam int LVL_DIR = 0;
    localparam int LVL_TBL = LEVELS - 1;

    walk_st_e          st_q;
    logic [ADDR_W-1:0] lin_q;
    logic              wr_q;
    logic              usr_q;
    logic [ADDR_W-1:0] dir_q;
    logic [ADDR_W-1:0] tbl_q;
    logic [ADDR_W-1:0] phys_q;
    fault_e            fault_q;

    logic [ADDR_W-1:0] dir_addr;
    logic [ADDR_W-1:0] tbl_addr;
    logic [ADDR_W-1:0] xlat_phys;
    logic              is_large;
    logic              grant;

    logic [ADDR_W-1:0] lvl_ent [LEVELS];
    logic [ADDR_W-1:0] lvl_new [LEVELS];
    logic              lvl_wb  [LEVELS];

    // The large-page flag of the latched directory entry selects the leaf
    assign is_large = dir_q[BIT_PS];

    pt_addr_gen #(
        .ADDR_W     (ADDR_W),
        .PAGE_SHIFT (PAGE_SHIFT),
        .IDX_W      (IDX_W)
    ) u_addr (
        .lin_i        (lin_q),
        .base_frame_i (ctl_dir_base[ADDR_W-1:PAGE_SHIFT]),
        .dir_frame_i  (dir_q[ADDR_W-1:PAGE_SHIFT]),
        .tbl_frame_i  (tbl_q[ADDR_W-1:PAGE_SHIFT]),
        .large_i      (is_large),
        .dir_addr_o   (dir_addr),
        .tbl_addr_o   (tbl_addr),
        .phys_o       (xlat_phys)
    );

    pt_perm_check u_perm (
        .acc_user_i  (usr_q),
        .acc_write_i (wr_q),
        .large_i     (is_large),
        .dir_us_i    (dir_q[BIT_US]),
        .dir_rw_i    (dir_q[BIT_RW]),
        .tbl_us_i    (tbl_q[BIT_US]),
        .tbl_rw_i    (tbl_q[BIT_RW]),
        .grant_o     (grant)
    );

    assign lvl_ent[LVL_DIR] = dir_q;
    assign lvl_ent[LVL_TBL] = tbl_q;

    // One flag updater per level; only the table level may take dirty
    for (genvar g = 0; g < LEVELS; g++) begin : g_lvl
        pt_entry_upd #(
            .ENT_W (ADDR_W)
        ) u_upd (
            .entry_i      (lvl_ent[g]),
            .mark_dirty_i ((g == LVL_TBL) ? wr_q : 1'b0),
            .entry_o      (lvl_new[g]),
            .wb_need_o    (lvl_wb[g])
        );
    end

    // Walk sequencer: reads, checks, write-backs, response
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q    <= ST_IDLE;
            lin_q   <= '0;
            wr_q    <= 1'b0;
            usr_q   <= 1'b0;
            dir_q   <= '0;
            tbl_q   <= '0;
            phys_q  <= '0;
            fault_q <= FLT_NONE;
        end else begin
            case (st_q)
                ST_IDLE: begin
                    if (req_valid) begin
                        lin_q <= req_lin;
                        wr_q  <= req_write;
                        usr_q <= req_user;
                        if (!ctl_paging_en) begin
                            phys_q  <= req_lin;
                            fault_q <= FLT_NONE;
                            st_q    <= ST_DONE;
                        end else begin
                            st_q <= ST_DIR_RD;
                        end
                    end
                end
                ST_DIR_RD: begin
                    if (mem_ack) begin
                        dir_q <= mem_rdata;
                        st_q  <= ST_DIR_EV;
                    end
                end
                ST_DIR_EV: begin
                    if (!dir_q[BIT_P]) begin
                        fault_q <= FLT_DIR_ABSENT;
                        st_q    <= ST_DONE;
                    end else if (!is_large) begin
                        st_q <= ST_TBL_RD;
                    end else if (!grant) begin
                        fault_q <= FLT_PRIV;
                        st_q    <= ST_DONE;
                    end else begin
                        fault_q <= FLT_NONE;
                        phys_q  <= xlat_phys;
                        st_q    <= lvl_wb[LVL_DIR] ? ST_DIR_WB : ST_DONE;
                    end
                end
                ST_TBL_RD: begin
                    if (mem_ack) begin
                        tbl_q <= mem_rdata;
                        st_q  <= ST_TBL_EV;
                    end
                end
                ST_TBL_EV: begin
                    if (!tbl_q[BIT_P]) begin
                        fault_q <= FLT_TBL_ABSENT;
                        st_q    <= ST_DONE;
                    end else if (!grant) begin
                        fault_q <= FLT_PRIV;
                        st_q    <= ST_DONE;
                    end else begin
                        fault_q <= FLT_NONE;
                        phys_q  <= xlat_phys;
                        if (lvl_wb[LVL_DIR]) begin
                            st_q <= ST_DIR_WB;
                        end else if (lvl_wb[LVL_TBL]) begin
                            st_q <= ST_TBL_WB;
                        end else begin
                            st_q <= ST_DONE;
                        end
                    end
                end
                ST_DIR_WB: begin
                    if (mem_ack) begin
                        st_q <= (!is_large && lvl_wb[LVL_TBL]) ? ST_TBL_WB : ST_DONE;
                    end
                end
                ST_TBL_WB: begin
                    if (mem_ack) begin
                        st_q <= ST_DONE;
                    end
                end
                default: begin
                    st_q <= ST_IDLE;
                end
            endcase
        end
    end

    // Memory port drive: one access per read or write-back state
    always_comb begin
        mem_req   = (st_q == ST_DIR_RD) || (st_q == ST_TBL_RD) ||
                    (st_q == ST_DIR_WB) || (st_q == ST_TBL_WB);
        mem_we    = (st_q == ST_DIR_WB) || (st_q == ST_TBL_WB);
        mem_addr  = ((st_q == ST_DIR_RD) || (st_q == ST_DIR_WB)) ? dir_addr : tbl_addr;
        mem_wdata = (st_q == ST_DIR_WB) ? lvl_new[LVL_DIR] : lvl_new[LVL_TBL];
    end

    // Request and response handshake outputs
    always_comb begin
        req_ready = (st_q == ST_IDLE);
        rsp_valid = (st_q == ST_DONE);
        rsp_phys  = phys_q;
        rsp_fault = fault_q;
    end

endmodule

// File: rtl/pt_walker_chk.sv
// Module pt_walker_chk
// Port-level properties of the walker, bound into every instance.
// Assumes mem_ack only pulses while mem_req is high and the controls are
// steady while a walk is in flight.
module pt_walker_chk
    import pt_walker_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ctl_paging_en,
    input logic              req_valid,
    input logic              req_ready,
    input logic [ADDR_W-1:0] req_lin,
    input logic              rsp_valid,
    input logic [ADDR_W-1:0] rsp_phys,
    input logic [1:0]        rsp_fault,
    input logic              mem_req,
    input logic              mem_we,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [ADDR_W-1:0] mem_wdata,
    input logic              mem_ack
);
    // R10: a pending access holds its request and contents
    a_r10_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata));

    // R10: no memory traffic while idle
    a_r10_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> !mem_req);

    // R11: response strobe lasts a single cycle
    a_r11_rsp_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);

    // R2: untranslated request answered next cycle with the same address
    a_r2_passthru: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_ready && !ctl_paging_en |=>
            rsp_valid && (rsp_phys == $past(req_lin)) && (rsp_fault == 2'd0));

    // R7: every write-back carries present and accessed set
    a_r7_wb_flags: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && mem_we |-> mem_wdata[BIT_A] && mem_wdata[BIT_P]);

endmodule

bind pt_walker pt_walker_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .ctl_paging_en (ctl_paging_en),
    .req_valid     (req_valid),
    .req_ready     (req_ready),
    .req_lin       (req_lin),
    .rsp_valid     (rsp_valid),
    .rsp_phys      (rsp_phys),
    .rsp_fault     (rsp_fault),
    .mem_req       (mem_req),
    .mem_we        (mem_we),
    .mem_addr      (mem_addr),
    .mem_wdata     (mem_wdata),
    .mem_ack       (mem_ack)
);

// File: tb/pt_walker_test.sv
`timescale 1ns/1ps
// Scoreboard bench: the walk task queues the expected response, the
// monitor pops and compares it; a memory model answers the walker.
module pt_walker_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ctl_paging_en = 1'b0;
    logic [31:0] ctl_dir_base = 32'h0010_0000;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [31:0] req_lin = '0;
    logic        req_write = 1'b0;
    logic        req_user = 1'b0;
    logic        rsp_valid;
    logic [31:0] rsp_phys;
    logic [1:0]  rsp_fault;
    logic        mem_req;
    logic        mem_we;
    logic [31:0] mem_addr;
    logic [31:0] mem_wdata;
    logic        mem_ack = 1'b0;
    logic [31:0] mem_rdata = '0;

    pt_walker uut (
        .clk           (clk),
        .rst_n         (rst_n),
        .ctl_paging_en (ctl_paging_en),
        .ctl_dir_base  (ctl_dir_base),
        .req_valid     (req_valid),
        .req_ready     (req_ready),
        .req_lin       (req_lin),
        .req_write     (req_write),
        .req_user      (req_user),
        .rsp_valid     (rsp_valid),
        .rsp_phys      (rsp_phys),
        .rsp_fault     (rsp_fault),
        .mem_req       (mem_req),
        .mem_we        (mem_we),
        .mem_addr      (mem_addr),
        .mem_wdata     (mem_wdata),
        .mem_ack       (mem_ack),
        .mem_rdata     (mem_rdata)
    );

    always #2 clk = ~clk;

    typedef struct {
        logic [31:0] phys;
        logic [1:0]  flt;
        string       tag;
    } exp_t;

    exp_t        exp_q[$];
    exp_t        cur;
    int          n_checks = 0;
    int          n_fail = 0;
    int          rsp_cnt = 0;
    bit          prev_rsp = 0;
    bit          finished = 0;

    logic [31:0] mem_model [logic [31:0]];
    logic [31:0] wr_addrs[$];
    int          rd_count = 0;
    int          mem_lat = 0;
    int          wait_cnt = 0;
    logic [31:0] held_addr = '0;
    bit          held_valid = 0;
    int          hold_err = 0;

    function automatic logic [31:0] rd_word(input logic [31:0] a);
        return mem_model.exists(a) ? mem_model[a] : 32'h0;
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // Memory model: acknowledge a pending access after mem_lat idle cycles
    initial begin
        forever begin
            @(negedge clk);
            if (mem_ack) begin
                mem_ack = 1'b0;
                held_valid = 0;
            end else if (mem_req) begin
                if (!held_valid) begin
                    held_addr = mem_addr;
                    held_valid = 1;
                end else if (held_addr != mem_addr) begin
                    hold_err++;
                end
                if (wait_cnt >= mem_lat) begin
                    wait_cnt = 0;
                    mem_ack = 1'b1;
                    if (mem_we) begin
                        mem_model[mem_addr] = mem_wdata;
                        wr_addrs.push_back(mem_addr);
                    end else begin
                        mem_rdata = rd_word(mem_addr);
                        rd_count++;
                    end
                end else begin
                    wait_cnt++;
                end
            end
        end
    end

    // Monitor: pop the expected item on every response and compare
    always @(negedge clk) begin
        if (rst_n && rsp_valid) begin
            if (exp_q.size() == 0) begin
                chk(0, "R11", "response without request", 32'h1, 32'h0);
            end else begin
                cur = exp_q.pop_front();
                chk(rsp_fault == cur.flt, cur.tag, "fault code", {30'h0, rsp_fault}, {30'h0, cur.flt});
                if (cur.flt == 2'd0) begin
                    chk(rsp_phys == cur.phys, cur.tag, "physical address", rsp_phys, cur.phys);
                end
                chk(wr_addrs.size() <= 2, "R9", "write-backs done before response", wr_addrs.size(), 2);
            end
            if (prev_rsp) chk(0, "R11", "response longer than one cycle", 32'h1, 32'h0);
            rsp_cnt++;
        end
        prev_rsp = rst_n && rsp_valid;
    end

    // Driver: queue the expectation, offer one request, wait for its answer
    task automatic walk(input logic [31:0] lin, input logic wr, input logic usr,
                        input logic [31:0] phys, input logic [1:0] flt, input string tag);
        int n;
        exp_t e;
        e.phys = phys; e.flt = flt; e.tag = tag;
        exp_q.push_back(e);
        wr_addrs.delete();
        rd_count = 0;
        n = rsp_cnt;
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1; req_lin = lin; req_write = wr; req_user = usr;
        @(negedge clk);
        req_valid = 1'b0;
        chk(!req_ready, "R11", "busy after acceptance", {31'h0, req_ready}, 32'h0);
        while (rsp_cnt == n) @(negedge clk);
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    endtask

    // Watchdog
    initial begin
        repeat (100000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        // R1: reset values
        repeat (3) @(negedge clk);
        chk(req_ready == 1'b1, "R1", "req_ready in reset", {31'h0, req_ready}, 32'h1);
        chk(rsp_valid == 1'b0, "R1", "rsp_valid in reset", {31'h0, rsp_valid}, 32'h0);
        chk(mem_req == 1'b0, "R1", "mem_req in reset", {31'h0, mem_req}, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(req_ready && !rsp_valid && !mem_req, "R1", "idle after reset",
            {29'h0, req_ready, rsp_valid, mem_req}, 32'h4);

        // Page tables
        mem_model[32'h0010_0004] = 32'h0020_0003;   // dir 1: P RW, supervisor only
        mem_model[32'h0020_0004] = 32'h1234_5003;   // tbl 1: P RW
        mem_model[32'h0010_0008] = 32'h0030_0003;   // dir 2: table absent below
        mem_model[32'h0010_000C] = 32'h0040_0007;   // dir 3: P RW US
        mem_model[32'h0040_0000] = 32'h5555_5005;   // read-only user page
        mem_model[32'h0040_0004] = 32'h6666_60A7;   // PS set in a table entry
        mem_model[32'h0010_00C0] = 32'hABD0_0087;   // large page, low frame bits set
        mem_model[32'h0010_00C4] = 32'h7FC0_0081;   // large page, supervisor only

        // R2: translation off, write and user flags have no effect
        walk(32'hDEAD_BEEF, 1'b1, 1'b1, 32'hDEAD_BEEF, 2'd0, "R2");
        chk(rd_count == 0 && wr_addrs.size() == 0, "R2", "memory untouched", rd_count, 0);
        ctl_paging_en = 1'b1;

        // R3 R7 R9: first walk of a 4 KB page sets accessed, directory first
        walk(32'h0040_1234, 1'b0, 1'b0, 32'h1234_5234, 2'd0, "R3");
        chk(rd_count == 2, "R3", "two entry reads", rd_count, 2);
        chk(wr_addrs.size() == 2, "R7", "write-back count", wr_addrs.size(), 2);
        if (wr_addrs.size() == 2) begin
            chk(wr_addrs[0] == 32'h0010_0004, "R9", "first write-back is directory", wr_addrs[0], 32'h0010_0004);
            chk(wr_addrs[1] == 32'h0020_0004, "R9", "second write-back is table", wr_addrs[1], 32'h0020_0004);
        end
        chk(rd_word(32'h0010_0004) == 32'h0020_0023, "R7", "directory accessed", rd_word(32'h0010_0004), 32'h0020_0023);
        chk(rd_word(32'h0020_0004) == 32'h1234_5023, "R7", "table accessed", rd_word(32'h0020_0004), 32'h1234_5023);

        // R7: already accessed, no write-back
        mem_lat = 2;
        walk(32'h0040_1FFF, 1'b0, 1'b0, 32'h1234_5FFF, 2'd0, "R3");
        chk(wr_addrs.size() == 0, "R7", "no write-back when accessed", wr_addrs.size(), 0);

        // R8: supervisor write marks the table entry dirty only
        walk(32'h0040_1234, 1'b1, 1'b0, 32'h1234_5234, 2'd0, "R8");
        chk(wr_addrs.size() == 1, "R8", "single write-back", wr_addrs.size(), 1);
        chk(rd_word(32'h0020_0004) == 32'h1234_5063, "R8", "table dirty", rd_word(32'h0020_0004), 32'h1234_5063);
        chk(rd_word(32'h0010_0004) == 32'h0020_0023, "R8", "directory not dirty", rd_word(32'h0010_0004), 32'h0020_0023);

        // R4 R8: large page user write, one read, no dirty in the directory
        mem_lat = 1;
        walk(32'h0C12_3456, 1'b1, 1'b1, 32'hABD2_3456, 2'd0, "R4");
        chk(rd_count == 1, "R4", "no table read", rd_count, 1);
        chk(rd_word(32'h0010_00C0) == 32'hABD0_00A7, "R8", "large leaf accessed not dirty",
            rd_word(32'h0010_00C0), 32'hABD0_00A7);

        // R6: user read of a supervisor large page
        walk(32'h0C40_0000, 1'b0, 1'b1, 32'h0, 2'd3, "R6");
        chk(wr_addrs.size() == 0 && rd_word(32'h0010_00C4) == 32'h7FC0_0081, "R6", "refused large walk unchanged",
            rd_word(32'h0010_00C4), 32'h7FC0_0081);

        // R5: directory entry absent
        walk(32'h0800_0000, 1'b0, 1'b0, 32'h0, 2'd1, "R5");
        chk(rd_count == 1 && wr_addrs.size() == 0, "R5", "stop at directory", rd_count, 1);

        // R5: table entry absent, directory keeps accessed clear
        walk(32'h0080_0000, 1'b1, 1'b0, 32'h0, 2'd2, "R5");
        chk(wr_addrs.size() == 0, "R5", "no write-back on absent table", wr_addrs.size(), 0);
        chk(rd_word(32'h0010_0008) == 32'h0030_0003, "R5", "directory unchanged", rd_word(32'h0010_0008), 32'h0030_0003);

        // R6: user access through a supervisor directory entry
        mem_lat = 0;
        walk(32'h0040_1000, 1'b0, 1'b1, 32'h0, 2'd3, "R6");
        chk(wr_addrs.size() == 0, "R6", "no write-back on refusal", wr_addrs.size(), 0);

        // R6 R7: user read of a read-only user page
        walk(32'h00C0_0010, 1'b0, 1'b1, 32'h5555_5010, 2'd0, "R6");
        chk(rd_word(32'h0010_000C) == 32'h0040_0027, "R7", "user directory accessed", rd_word(32'h0010_000C), 32'h0040_0027);
        chk(rd_word(32'h0040_0000) == 32'h5555_5025, "R7", "user table accessed", rd_word(32'h0040_0000), 32'h5555_5025);

        // R6: user write to the read-only page is refused
        walk(32'h00C0_0010, 1'b1, 1'b1, 32'h0, 2'd3, "R6");
        chk(rd_word(32'h0040_0000) == 32'h5555_5025, "R6", "read-only entry unchanged", rd_word(32'h0040_0000), 32'h5555_5025);

        // R6 R8: supervisor write ignores the writable flag
        walk(32'h00C0_0010, 1'b1, 1'b0, 32'h5555_5010, 2'd0, "R6");
        chk(rd_word(32'h0040_0000) == 32'h5555_5065, "R8", "supervisor write dirty", rd_word(32'h0040_0000), 32'h5555_5065);

        // R4: large-page flag in a table entry is ignored
        mem_lat = 2;
        walk(32'h00C0_1ABC, 1'b0, 1'b0, 32'h6666_6ABC, 2'd0, "R4");
        chk(rd_count == 2 && wr_addrs.size() == 0, "R4", "table flag ignored", rd_count, 2);

        // R10: addresses held while waiting for acknowledge
        chk(hold_err == 0, "R10", "address stable while pending", hold_err, 0);
        chk(exp_q.size() == 0, "R11", "every request answered", exp_q.size(), 0);

        repeat (4) @(negedge clk);
        finish_run();
    end

endmodule